// File: doc/BRIEF.md
# Serial Bus Pause Controller

This block sits between the synchronized pins of a serial memory slave and its command engine. It watches the select, clock and pause lines and emits clock-edge strobes that the command engine uses to shift bits in and out. While the master holds the pause line low, those strobes are withheld. The command engine therefore sees a frozen bus, and the transfer carries on from the same bit once the pause is lifted.

The pause line acts on the serial output driver at once: a low level forces the output to high impedance in the same cycle, whatever the clock is doing. The pause itself starts and ends only while the serial clock is low. A pause request that arrives with the clock high is parked until the next falling clock edge. A release that arrives with the clock high has no effect until the clock is low with the pause line still high. The select line is honoured at all times: deselecting the device during a pause drops the pause and returns the block to idle.

The controller is a four-state machine:
- `ST_IDLE`: deselected.
- `ST_RUN`: selected, strobes forwarded.
- `ST_ARMED`: pause requested with the clock high, entry waiting for a falling edge.
- `ST_PAUSED`: strobes held back.

Its transitions are:
- Select: `ST_IDLE` to `ST_RUN` when `cs_n` is low.
- Deselect: any state to `ST_IDLE` when `cs_n` is high.
- Direct entry: `ST_RUN` to `ST_PAUSED` when `hold_n` is low and `sck` is low.
- Arm: `ST_RUN` to `ST_ARMED` when `hold_n` is low and `sck` is high.
- Cancel: `ST_ARMED` to `ST_RUN` when `hold_n` goes high again.
- Deferred entry: `ST_ARMED` to `ST_PAUSED` when `sck` is low and `hold_n` is still low.
- Resume: `ST_PAUSED` to `ST_RUN` when `hold_n` is high and `sck` is low.

Top module: `hold_pause_ctrl`

## Requirements
- R1: While `cs_n` is high, `sck_rise_o`, `sck_fall_o` and `paused_o` are 0 and `so_hiz_o` is 1. After select, the first clock edge is forwarded no earlier than the second cycle with `cs_n` low.
- R2: In any cycle where `hold_n` is 0, `so_hiz_o` is 1 in that same cycle, regardless of `sck`.
- R3: While `paused_o` is 1, no `sck_rise_o` or `sck_fall_o` pulse is emitted, whatever `sck` does.
- R4: While running and with `hold_n` high, each 0-to-1 change of `sck` between consecutive cycles gives one `sck_rise_o` pulse in the cycle the new level is seen. Each 1-to-0 change gives one `sck_fall_o` pulse in the same way.
- R5: When running, `hold_n` low with `sck` low makes `paused_o` 1 from the next cycle, unless `cs_n` rises.
- R6: When running, `hold_n` low with `sck` high does not pause in the next cycle. `so_hiz_o` is 1 at once. The pause starts in the cycle after `sck` is first seen low with `hold_n` still low. If `hold_n` returns high before that, the block goes back to running with no pause.
- R7: A pause ends, with `paused_o` 0 in the next cycle, only after a cycle where `hold_n` is high and `sck` is low. `hold_n` high with `sck` high keeps the pause.
- R8: `cs_n` high during a pause clears `paused_o` in that same cycle, and the block is idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Synchronized select, active low |
| sck | input | 1 | Synchronized serial clock level |
| hold_n | input | 1 | Synchronized pause request, active low |
| sck_rise_o | output | 1 | Gated rising-edge strobe of the serial clock |
| sck_fall_o | output | 1 | Gated falling-edge strobe of the serial clock |
| paused_o | output | 1 | Transfer currently paused |
| so_hiz_o | output | 1 | Force serial output to high impedance |

## Verification
The assertions assume that `cs_n`, `sck` and `hold_n` have already been synchronized to `clk` and are stable for a whole cycle. They also assume that each change of `sck` lasts at least one cycle, so that an edge is always seen as a level difference between two successive samples. The stimulus changes these inputs only once per cycle, away from the clock edge. It toggles `sck` with a bounded probability, and it mixes directed sequences with random ones: pauses started with the clock high and with it low, cancelled requests, releases with the clock high, and deselect during a pause.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_ARMED  = 2'd2,
        ST_PAUSED = 2'd3
    } hpc_state_e;
endpackage

// File: rtl/hpc_sck_edges.sv
// Registers the serial clock level and derives raw edge pulses.
module hpc_sck_edges #(
    parameter bit IDLE_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic rise,
    output logic fall
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= IDLE_LEVEL;
        else        sck_q <= sck;
    end

    assign rise = sck & ~sck_q;
    assign fall = ~sck & sck_q;
endmodule

// File: rtl/hpc_fsm.sv
// Pause state machine: entry and exit are qualified by the clock level.
module hpc_fsm
    import hpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       hold_n,
    output hpc_state_e state
);
    hpc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_RUN;
                ST_RUN: begin
                    if (!hold_n) state_d = sck ? ST_ARMED : ST_PAUSED;
                end
                ST_ARMED: begin
                    if (hold_n)    state_d = ST_RUN;
                    else if (!sck) state_d = ST_PAUSED;
                end
                ST_PAUSED: begin
                    if (hold_n && !sck) state_d = ST_RUN;
                end
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    assign state = state_q;
endmodule

// File: rtl/hpc_gate.sv
// Output decode: strobe gating, pause flag and output float.
module hpc_gate
    import hpc_pkg::*;
(
    input  hpc_state_e state,
    input  logic       cs_n,
    input  logic       hold_n,
    input  logic       raw_rise,
    input  logic       raw_fall,
    output logic       rise_o,
    output logic       fall_o,
    output logic       paused_o,
    output logic       hiz_o
);
    logic forward;

    always_comb begin
        forward  = 1'b0;
        paused_o = 1'b0;
        hiz_o    = cs_n | ~hold_n;
        unique case (state)
            ST_IDLE:   forward = 1'b0;
            ST_RUN:    forward = ~cs_n & hold_n;
            ST_ARMED: begin
                forward = ~cs_n & hold_n;
                hiz_o   = 1'b1;
            end
            ST_PAUSED: begin
                paused_o = ~cs_n;
                hiz_o    = 1'b1;
            end
            default:   forward = 1'b0;
        endcase
        rise_o = raw_rise & forward;
        fall_o = raw_fall & forward;
    end
endmodule

// File: rtl/hold_pause_ctrl.sv
module hold_pause_ctrl
    import hpc_pkg::*;
#(
    parameter bit SCK_IDLE_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic paused_o,
    output logic so_hiz_o
);
    logic       raw_rise, raw_fall;
    hpc_state_e fsm_state;

    hpc_sck_edges #(.IDLE_LEVEL(SCK_IDLE_LEVEL)) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .sck  (sck),
        .rise (raw_rise),
        .fall (raw_fall)
    );

    hpc_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sck   (sck),
        .hold_n(hold_n),
        .state (fsm_state)
    );

    hpc_gate u_gate (
        .state   (fsm_state),
        .cs_n    (cs_n),
        .hold_n  (hold_n),
        .raw_rise(raw_rise),
        .raw_fall(raw_fall),
        .rise_o  (sck_rise_o),
        .fall_o  (sck_fall_o),
        .paused_o(paused_o),
        .hiz_o   (so_hiz_o)
    );
endmodule

// File: rtl/hold_pause_chk.sv
module hold_pause_chk
    import hpc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sck,
    input logic       hold_n,
    input hpc_state_e state,
    input logic       sck_rise_o,
    input logic       sck_fall_o,
    input logic       paused_o,
    input logic       so_hiz_o
);
    p_deselected_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (so_hiz_o && !sck_rise_o && !sck_fall_o && !paused_o));

    p_hold_floats_output_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n |-> so_hiz_o);

    p_no_strobe_paused_r3: assert property (@(posedge clk) disable iff (!rst_n)
        paused_o |-> (!sck_rise_o && !sck_fall_o));

    p_rise_forwarded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !cs_n && hold_n && sck && !$past(sck)) |-> sck_rise_o);

    p_direct_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !cs_n && !hold_n && !sck) |=> (paused_o || cs_n));

    p_deferred_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !cs_n && !hold_n && sck) |=> !paused_o);

    p_pause_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (paused_o && !(hold_n && !sck)) |=> (paused_o || cs_n));

    p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (paused_o && hold_n && !sck) |=> !paused_o);

    p_deselect_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !paused_o);
endmodule

bind hold_pause_ctrl hold_pause_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sck       (sck),
    .hold_n    (hold_n),
    .state     (fsm_state),
    .sck_rise_o(sck_rise_o),
    .sck_fall_o(sck_fall_o),
    .paused_o  (paused_o),
    .so_hiz_o  (so_hiz_o)
);

// File: tb/sim_hold_pause_ctrl.sv
`timescale 1ns/1ps
module sim_hold_pause_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1;
    logic sck_rise_o, sck_fall_o, paused_o, so_hiz_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench reference: 0 idle, 1 run, 2 waiting for fall, 3 paused
    int    m_st   = 0;
    logic  m_sckp = 1'b0;
    string p_tag  = "R1";

    always #4 clk = ~clk;

    hold_pause_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .sck_rise_o(sck_rise_o), .sck_fall_o(sck_fall_o),
        .paused_o(paused_o), .so_hiz_o(so_hiz_o)
    );

    function automatic logic exp_pass(int st, logic c, logic h);
        return !c && h && (st == 1 || st == 2);
    endfunction

    function automatic string strobe_tag(int st, logic c);
        if (c)        return "R1";
        if (st == 3)  return "R3";
        return "R4";
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(logic c, logic s, logic h);
        logic e_rise, e_fall, e_hiz, e_paused;
        @(negedge clk);
        cs_n = c; sck = s; hold_n = h;
        #3;
        e_rise   = s && !m_sckp && exp_pass(m_st, c, h);
        e_fall   = !s && m_sckp && exp_pass(m_st, c, h);
        e_hiz    = c || !h || m_st >= 2;
        e_paused = (m_st == 3) && !c;
        chk(strobe_tag(m_st, c), "rise", sck_rise_o, e_rise);
        chk(strobe_tag(m_st, c), "fall", sck_fall_o, e_fall);
        chk(c ? "R1" : (!h ? "R2" : "R6"), "hiz", so_hiz_o, e_hiz);
        chk(c ? (m_st == 3 ? "R8" : "R1") : p_tag, "paused", paused_o, e_paused);
        // advance reference to the state after the coming edge
        if (c) begin
            p_tag = (m_st == 3) ? "R8" : "R1";
            m_st = 0;
        end else begin
            case (m_st)
                0: begin m_st = 1; p_tag = "R1"; end
                1: begin
                    if (!h && !s)     begin m_st = 3; p_tag = "R5"; end
                    else if (!h)      begin m_st = 2; p_tag = "R6"; end
                    else                    p_tag = "R4";
                end
                2: begin
                    p_tag = "R6";
                    if (h)            m_st = 1;
                    else if (!s)      m_st = 3;
                end
                default: begin
                    p_tag = "R7";
                    if (h && !s)      m_st = 1;
                end
            endcase
        end
        m_sckp = s;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset and deselected state
        step(1, 0, 1); step(1, 1, 1); step(1, 0, 1);
        // select, a few clocked bits (R4)
        step(0, 0, 1); step(0, 0, 1);
        for (int i = 0; i < 4; i++) begin step(0, 1, 1); step(0, 0, 1); end
        // R5 direct entry, R3 clocks ignored, R7 release with clock high keeps pause
        step(0, 0, 0); step(0, 1, 0); step(0, 0, 0); step(0, 1, 0);
        step(0, 1, 1); step(0, 1, 1); step(0, 0, 1); step(0, 1, 1); step(0, 0, 1);
        // R6 request with clock high, entry at the falling edge
        step(0, 1, 1); step(0, 1, 0); step(0, 1, 0); step(0, 0, 0); step(0, 1, 0);
        step(0, 0, 1); step(0, 1, 1); step(0, 0, 1);
        // R6 request cancelled before the falling edge
        step(0, 1, 1); step(0, 1, 0); step(0, 1, 1); step(0, 0, 1); step(0, 1, 1);
        // R8 deselect during a pause
        step(0, 0, 1); step(0, 0, 0); step(0, 0, 0); step(1, 0, 0); step(1, 0, 1);
        step(0, 0, 1); step(0, 0, 1);
        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            logic c, s, h;
            c = cs_n; s = sck; h = hold_n;
            if ($urandom_range(99) < 3)  c = ~c;
            if ($urandom_range(99) < 40) s = ~s;
            if ($urandom_range(99) < 12) h = ~h;
            step(c, s, h);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule